// File: doc/BRIEF.md
# Receive Packet Buffer with Drop

This block sits between a 64-bit streaming receive port of an Ethernet MAC and a downstream packet consumer that must receive every packet as one unbroken burst. The MAC can stall its valid strobe in the middle of a packet and does not wait for back-pressure. The buffer therefore writes every accepted word, together with its empty count and its SOP, EOP and error flags, into an internal show-ahead FIFO. It keeps a count of the complete packets held, and it offers a packet to the consumer only after the packet's last word is stored.

Admission is decided per packet. The input ready signal changes only between packets. It rises when no input packet is in flight and the fill level is below a high-water mark. It drops at the end of a packet that leaves the FIFO at or above that mark. A packet whose first word arrives while ready is low is thrown away as a whole. With the mark set at least one maximum-size packet below the depth, the FIFO cannot overflow. Everything runs on a single clock.

Top module: `rx_pkt_buffer`

## Requirements
- R1: While reset is asserted, in_ready and out_valid are low. With an empty FIFO, in_ready is high in the first cycle after reset is released.
- R2: Every admitted word reaches the output unchanged and in arrival order. Each stored entry is 70 bits wide: data in bits 63:0, empty count in bits 66:64, EOP at bit 67, SOP at bit 68 and error at bit 69.
- R3: in_ready rises only when no input packet is in progress and the fill level after the current clock edge is below HIGH_MARK.
- R4: in_ready keeps its value from the first word of a packet through its last word. After the EOP word, in_ready falls if the fill level is at or above HIGH_MARK.
- R5: A packet whose SOP word arrives while in_ready is low is discarded completely, and none of its words appear at the output.
- R6: out_valid rises one cycle after a cycle in which the stored-packet count is nonzero and out_ready is high, and at no other time.
- R7: Once out_valid is high it stays high until the EOP word is transferred. With out_ready held high, the words of a packet leave on consecutive cycles.
- R8: out_valid is low in the cycle after the EOP word is transferred.
- R9: The stored-packet count rises by one when an EOP word is written and falls by one when an EOP word is released. It keeps its value when both happen in the same cycle.
- R10: The fill level never exceeds the FIFO depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | MAC word valid |
| in_ready | output | 1 | Buffer admits a new packet |
| in_data | input | 64 | MAC data word |
| in_empty | input | 3 | Unused byte count of the word |
| in_sop | input | 1 | First word of packet |
| in_eop | input | 1 | Last word of packet |
| in_err | input | 1 | MAC error flag |
| out_valid | output | 1 | Consumer word valid |
| out_ready | input | 1 | Consumer accepts word |
| out_data | output | 64 | Data word to consumer |
| out_empty | output | 3 | Unused byte count |
| out_sop | output | 1 | First word of packet |
| out_eop | output | 1 | Last word of packet |
| out_err | output | 1 | Error flag |

## Verification
The bench builds the buffer with a 64-entry FIFO (DEPTH_LOG2 = 6) and HIGH_MARK = 46, which leaves room for the 18-word worst-case packet the stimulus uses. With these values, a stalled consumer fills the FIFO past the mark after four 12-word packets. That brings the ready drop at EOP, whole-packet discards and the later recovery within a few hundred cycles. Random packet lengths, mid-packet valid gaps and a randomly stalling consumer exercise cycles where an EOP word is stored and another is released at the same time.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int DATA_W  = 64;
  localparam int EMPTY_W = 3;

  // Packed layout, MSB first: err(69) sop(68) eop(67) empty(66:64) data(63:0)
  typedef struct packed {
    logic               err;
    logic               sop;
    logic               eop;
    logic [EMPTY_W-1:0] empty;
    logic [DATA_W-1:0]  data;
  } entry_t;
endpackage

// File: rtl/rxbuf_fifo.sv
module rxbuf_fifo
  import rxbuf_pkg::*;
#(
  parameter int DEPTH_LOG2 = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  entry_t              wr_data,
  input  logic                rd_en,
  output entry_t              rd_data,
  output logic [DEPTH_LOG2:0] fill,
  output logic [DEPTH_LOG2:0] fill_nxt
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  entry_t                  mem [DEPTH];
  logic [DEPTH_LOG2-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [DEPTH_LOG2:0]     fill_q, fill_d;

  always_comb begin
    wp_d   = wr_en ? wp_q + 1'b1 : wp_q;
    rp_d   = rd_en ? rp_q + 1'b1 : rp_q;
    fill_d = fill_q;
    case ({wr_en, rd_en})
      2'b10:   fill_d = fill_q + 1'b1;
      2'b01:   fill_d = fill_q - 1'b1;
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      fill_q <= fill_d;
    end
  end

  // storage array: no reset, written only under the write enable
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  // show-ahead: head entry visible without a read strobe
  assign rd_data  = mem[rp_q];
  assign fill     = fill_q;
  assign fill_nxt = fill_d;
endmodule

// File: rtl/rxbuf_admit.sv
module rxbuf_admit #(
  parameter int DEPTH_LOG2 = 12,
  parameter int HIGH_MARK  = 2944
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sop,
  input  logic                in_eop,
  input  logic [DEPTH_LOG2:0] fill_nxt,
  output logic                in_ready,
  output logic                busy,
  output logic                wr_en
);
  localparam int CNT_W = DEPTH_LOG2 + 1;
  localparam logic [CNT_W-1:0] MARK_V = CNT_W'(HIGH_MARK);

  logic ready_q, ready_d, busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (in_valid) begin
      if (in_eop)      busy_d = 1'b0;
      else if (in_sop) busy_d = 1'b1;
    end
    // ready only moves between packets; held across a packet in flight
    if (busy_d) ready_d = ready_q;
    else        ready_d = (fill_nxt < MARK_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      ready_q <= ready_d;
      busy_q  <= busy_d;
    end
  end

  assign in_ready = ready_q;
  assign busy     = busy_q;
  assign wr_en    = in_valid & ready_q;
endmodule

// File: rtl/rxbuf_pkt_count.sv
module rxbuf_pkt_count #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    case ({inc, dec})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rxbuf_egress.sv
module rxbuf_egress (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_avail,
  input  logic head_eop,
  input  logic out_ready,
  output logic out_valid,
  output logic rd_en
);
  logic valid_q, valid_d;

  always_comb begin
    if (valid_q) valid_d = !(out_ready && head_eop);
    else         valid_d = pkt_avail && out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign out_valid = valid_q;
  assign rd_en     = valid_q & out_ready;
endmodule

// File: rtl/rx_pkt_buffer.sv
module rx_pkt_buffer
  import rxbuf_pkg::*;
#(
  parameter int DEPTH_LOG2 = 12,
  parameter int HIGH_MARK  = 2944
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic               in_err,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic [EMPTY_W-1:0] out_empty,
  output logic               out_sop,
  output logic               out_eop,
  output logic               out_err
);
  localparam int CNT_W = DEPTH_LOG2 + 1;

  entry_t             wr_word, head;
  logic               wr_en, rd_en, busy;
  logic [CNT_W-1:0]   fill, fill_nxt, pkt_cnt;

  assign wr_word = '{err: in_err, sop: in_sop, eop: in_eop,
                     empty: in_empty, data: in_data};

  rxbuf_admit #(.DEPTH_LOG2(DEPTH_LOG2), .HIGH_MARK(HIGH_MARK)) u_admit (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .fill_nxt (fill_nxt),
    .in_ready (in_ready),
    .busy     (busy),
    .wr_en    (wr_en)
  );

  rxbuf_fifo #(.DEPTH_LOG2(DEPTH_LOG2)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_word),
    .rd_en    (rd_en),
    .rd_data  (head),
    .fill     (fill),
    .fill_nxt (fill_nxt)
  );

  rxbuf_pkt_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (wr_en & in_eop),
    .dec   (rd_en & head.eop),
    .cnt   (pkt_cnt)
  );

  rxbuf_egress u_egress (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_avail (pkt_cnt != '0),
    .head_eop  (head.eop),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .rd_en     (rd_en)
  );

  assign out_data  = head.data;
  assign out_empty = head.empty;
  assign out_sop   = head.sop;
  assign out_eop   = head.eop;
  assign out_err   = head.err;
endmodule

// File: rtl/rx_pkt_buffer_chk.sv
module rx_pkt_buffer_chk #(
  parameter int DEPTH_LOG2 = 12,
  parameter int HIGH_MARK  = 2944
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                in_eop,
  input logic                out_valid,
  input logic                out_ready,
  input logic                out_eop,
  input logic                busy,
  input logic                wr_en,
  input logic                rd_en,
  input logic [DEPTH_LOG2:0] fill,
  input logic [DEPTH_LOG2:0] pkt_cnt
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  p_ready_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (!busy && fill < (DEPTH_LOG2+1)'(HIGH_MARK)));

  p_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(in_valid && in_eop)) |=> $stable(in_ready));

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !rd_en) |=> (fill <= $past(fill)));

  p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(pkt_cnt != '0 && out_ready));

  p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && out_eop)) |=> out_valid);

  p_valid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> !out_valid);

  p_cnt_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_eop && rd_en && out_eop) |=> $stable(pkt_cnt));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (DEPTH_LOG2+1)'(DEPTH));
endmodule

bind rx_pkt_buffer rx_pkt_buffer_chk #(
  .DEPTH_LOG2(DEPTH_LOG2), .HIGH_MARK(HIGH_MARK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
  .out_eop(out_eop), .busy(busy), .wr_en(wr_en), .rd_en(rd_en),
  .fill(fill), .pkt_cnt(pkt_cnt)
);

// File: tb/test_rx_pkt_buffer.sv
`timescale 1ns/1ps
module test_rx_pkt_buffer;
  localparam int DL   = 6;
  localparam int DEP  = 1 << DL;
  localparam int MARK = 46;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iv = 1'b0, isop = 1'b0, ieop = 1'b0, ierr = 1'b0;
  logic [63:0] idata = '0;
  logic [2:0]  iempty = '0;
  logic        ordy = 1'b1;
  logic        in_ready, out_valid, out_sop, out_eop, out_err;
  logic [63:0] out_data;
  logic [2:0]  out_empty;

  always #5 clk = ~clk;

  rx_pkt_buffer #(.DEPTH_LOG2(DL), .HIGH_MARK(MARK)) i_rx_pkt_buffer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iv), .in_ready(in_ready), .in_data(idata), .in_empty(iempty),
    .in_sop(isop), .in_eop(ieop), .in_err(ierr),
    .out_valid(out_valid), .out_ready(ordy), .out_data(out_data),
    .out_empty(out_empty), .out_sop(out_sop), .out_eop(out_eop),
    .out_err(out_err)
  );

  int checks = 0, errors = 0;
  int sent = 0, dropped = 0, delivered = 0;
  int ordy_mode = 0;   // 0: always ready, 1: stalled, 2: random
  bit dropped_id [int];

  // behavioural reference model
  logic [69:0] mq[$];
  bit m_ready, m_busy, m_oval, out_mid;
  int m_pk;

  function automatic void chk(bit ok, string req, logic [69:0] act, logic [69:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endfunction

  always @(negedge clk) begin
    case (ordy_mode)
      0: ordy <= 1'b1;
      1: ordy <= 1'b0;
      default: ordy <= 1'(($urandom_range(99)) < 60);
    endcase
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_ready = 0; m_busy = 0; m_oval = 0; m_pk = 0; out_mid = 0;
    end else begin
      bit wr, rd, deop, nb, nv;
      wr   = iv && m_ready;
      rd   = m_oval && ordy;
      deop = rd && (mq.size() > 0) && mq[0][67];
      nv   = m_oval ? !deop : (m_pk != 0 && ordy);
      // output-side bookkeeping on the actual DUT transfer
      if (out_valid && ordy) begin
        if (out_sop) begin
          delivered++;
          if (dropped_id.exists(int'(out_data[63:32])))
            chk(0, "R5 dropped packet delivered", {38'd0, out_data[63:32]}, 70'd0);
        end
        out_mid = !out_eop;
      end
      if (rd && mq.size() > 0) void'(mq.pop_front());
      if (wr) mq.push_back({ierr, isop, ieop, iempty, idata});
      m_pk = m_pk + ((wr && ieop) ? 1 : 0) - (deop ? 1 : 0);
      nb = m_busy;
      if (iv) begin
        if (ieop)      nb = 0;
        else if (isop) nb = 1;
      end
      if (!nb) m_ready = (mq.size() < MARK);
      m_busy = nb;
      m_oval = nv;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready == m_ready, m_busy ? "R4 in_ready" : "R3 in_ready",
          {69'd0, in_ready}, {69'd0, m_ready});
      chk(out_valid == m_oval, m_oval ? "R7 out_valid" : "R6 R8 R9 out_valid",
          {69'd0, out_valid}, {69'd0, m_oval});
      if (out_valid && m_oval && mq.size() > 0)
        chk({out_err, out_sop, out_eop, out_empty, out_data} == mq[0], "R2 word",
            {out_err, out_sop, out_eop, out_empty, out_data}, mq[0]);
      if (out_mid)
        chk(out_valid, "R7 gap inside packet", {69'd0, out_valid}, 70'd1);
      chk(mq.size() <= DEP, "R10 fill", 70'(mq.size()), 70'(DEP));
    end
  end

  task automatic send_pkt(int id, int len, int gap_pct);
    for (int w = 0; w < len; w++) begin
      while (int'($urandom_range(99)) < gap_pct) begin
        iv = 0; isop = 0; ieop = 0;
        @(negedge clk);
      end
      if (w == 0) begin
        sent++;
        if (!in_ready) begin dropped++; dropped_id[id] = 1; end
      end
      iv     = 1;
      idata  = {id[31:0], w[31:0]};
      isop   = (w == 0);
      ieop   = (w == len - 1);
      iempty = (w == len - 1) ? 3'($urandom_range(7)) : 3'd0;
      ierr   = (w == len - 1) ? 1'($urandom_range(1)) : 1'b0;
      @(negedge clk);
    end
    iv = 0; isop = 0; ieop = 0; ierr = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    int id;
    id = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!in_ready, "R1 in_ready in reset", {69'd0, in_ready}, 70'd0);
    chk(!out_valid, "R1 out_valid in reset", {69'd0, out_valid}, 70'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready, "R1 in_ready after release", {69'd0, in_ready}, 70'd1);

    // random packets with gaps, consumer always ready
    ordy_mode = 0;
    for (int p = 0; p < 30; p++) begin
      send_pkt(id, $urandom_range(1, 16), 30); id++;
    end
    repeat (40) @(negedge clk);

    // stalled consumer: fill crosses the mark, later packets dropped
    ordy_mode = 1;
    for (int p = 0; p < 8; p++) begin
      send_pkt(id, 12, 0); id++;
    end
    repeat (3) @(negedge clk);
    chk(!in_ready, "R4 ready low above mark", {69'd0, in_ready}, 70'd0);
    chk(dropped == 4, "R5 drop count while full", 70'(dropped), 70'd4);
    ordy_mode = 0;
    repeat (120) @(negedge clk);
    chk(in_ready, "R3 ready back after drain", {69'd0, in_ready}, 70'd1);

    // random stalls on both sides
    ordy_mode = 2;
    for (int p = 0; p < 60; p++) begin
      send_pkt(id, $urandom_range(1, 18), 20); id++;
    end
    repeat (10) @(negedge clk);
    ordy_mode = 0;
    repeat (300) @(negedge clk);

    chk(delivered == sent - dropped, "R5 delivered packets",
        70'(delivered), 70'(sent - dropped));
    chk(mq.size() == 0, "R2 all words delivered", 70'(mq.size()), 70'd0);
    chk(!out_valid, "R8 idle at end", {69'd0, out_valid}, 70'd0);
    finish_run();
  end
endmodule